// File: doc/BRIEF.md
# Sound Generator Register Front End

This block sits between the processor bus and the five voice channels of a sound generator. A bus write anywhere in a 24-byte window starting at the base address is turned into a one-cycle write enable for the addressed register slot, with the write data held beside it. Four slots in the window are unused and never strobe. The slot at offset 0x15 is special. Writing it sets the five channel enable bits. Reading it returns a status byte built from the channels' length-nonzero lines, the sample channel's busy line and the two interrupt flags.

For the four tone channels, a write to the channel's length slot also produces a length-load pulse. The pulse carries a reload value looked up from a fixed 32-entry table, indexed by the upper five data bits. The block keeps a frame interrupt flag and a sample interrupt flag. A read of the status slot clears the first, and a write to the enable slot clears the second. The interrupt output is high while either flag is set. The slot at offset 0x17 holds an inhibit bit that blocks and clears the frame flag.

Top module: `apu_reg_front`

## Requirements
- R1: A bus write to a used slot of the window (base address plus offset 0x00 to 0x17) raises bit [offset] of reg_we_o for exactly one cycle, on the clock edge after the write, with reg_wdata_o equal to the written byte; at most one bit of reg_we_o is ever high.
- R2: Writes to offsets 0x09, 0x0D, 0x14 and 0x16, and writes to addresses outside the window, raise no bit of reg_we_o and no length-load pulse.
- R3: While bus_rd is high at offset 0x15, rd_data_o shows in the same cycle: bits 3:0 the len_nz_i lines (tone channels 0 to 3), bit 4 sample_busy_i, bit 5 zero, bit 6 the frame interrupt flag, bit 7 the sample interrupt flag.
- R4: When no status read is in progress, rd_data_o is zero, and the read changes neither flag.
- R5: A status read clears the frame interrupt flag from the next cycle on, and leaves the sample interrupt flag unchanged.
- R6: A frame_irq_set_i pulse sets the frame flag unless the inhibit bit (bit 6 of the last write to offset 0x17) is set. Writing offset 0x17 with bit 6 set clears the flag. A set in the same cycle as a status read wins.
- R7: A write to offset 0x15 sets ch_en_o to data bits 4:0 from the next cycle on. It also clears the sample interrupt flag and leaves the frame flag alone. dmc_irq_set_i sets the sample flag, and this set wins over a clear in the same cycle.
- R8: irq_o is high exactly when the frame flag or the sample flag is set.
- R9: A write to offset 4*c+3 (c = 0..3) raises len_load_o[c] for one cycle on the next edge only if ch_en_o[c] was high when the write occurred; otherwise no pulse.
- R10: len_value_o during a load is the table entry at data bits 7:3. The entries for indices 0 to 31 are: 10,254,20,2,40,4,80,6,160,8,60,10,14,12,26,14,12,16,24,18,48,20,96,22,192,24,72,26,16,28,32,30.
- R11: After reset, both flags, the inhibit bit, ch_en_o, reg_we_o and len_load_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| len_nz_i | input | 4 | Length counter nonzero, tone channels 0..3 |
| sample_busy_i | input | 1 | Sample channel still has bytes to play |
| frame_irq_set_i | input | 1 | Frame sequencer interrupt request pulse |
| dmc_irq_set_i | input | 1 | Sample channel interrupt request pulse |
| reg_we_o | output | 24 | Per-slot write enable, bit = offset |
| reg_wdata_o | output | 8 | Data of the last write |
| ch_en_o | output | 5 | Channel enable bits |
| len_load_o | output | 4 | Length reload pulse per tone channel |
| len_value_o | output | 8 | Length reload value |
| rd_data_o | output | 8 | Read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The decoder is exercised with a vector table that covers used slots in each channel group, the four holes, and addresses just above, just below and far outside the window. A stray strobe or a shifted bit position shows up on a single vector. The length lookup is swept over all 32 indices, and a disabled channel is written to show that its load is gated. The flag tests order reads, enable writes, inhibit writes and same-cycle set/clear collisions so that each flag's clear source is separated from the other's.

// File: rtl/apu_fe_pkg.sv
package apu_fe_pkg;

   localparam int SLOT_W    = 5;
   localparam int WIN_SLOTS = 24;
   localparam int TONE_CH   = 4;
   localparam int ALL_CH    = 5;

   localparam logic [SLOT_W-1:0] OFS_ENABLE = 5'h15;
   localparam logic [SLOT_W-1:0] OFS_FRAME  = 5'h17;

   function automatic logic slot_unused(input int idx);
      return (idx == 9) || (idx == 13) || (idx == 20) || (idx == 22);
   endfunction

   function automatic logic [7:0] len_lookup(input logic [4:0] idx);
      logic [7:0] v;
      case (idx)
         5'd0:  v = 8'd10;   5'd1:  v = 8'd254;
         5'd2:  v = 8'd20;   5'd3:  v = 8'd2;
         5'd4:  v = 8'd40;   5'd5:  v = 8'd4;
         5'd6:  v = 8'd80;   5'd7:  v = 8'd6;
         5'd8:  v = 8'd160;  5'd9:  v = 8'd8;
         5'd10: v = 8'd60;   5'd11: v = 8'd10;
         5'd12: v = 8'd14;   5'd13: v = 8'd12;
         5'd14: v = 8'd26;   5'd15: v = 8'd14;
         5'd16: v = 8'd12;   5'd17: v = 8'd16;
         5'd18: v = 8'd24;   5'd19: v = 8'd18;
         5'd20: v = 8'd48;   5'd21: v = 8'd20;
         5'd22: v = 8'd96;   5'd23: v = 8'd22;
         5'd24: v = 8'd192;  5'd25: v = 8'd24;
         5'd26: v = 8'd72;   5'd27: v = 8'd26;
         5'd28: v = 8'd16;   5'd29: v = 8'd28;
         5'd30: v = 8'd32;   default: v = 8'd30;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/apu_fe_decode.sv
module apu_fe_decode
   import apu_fe_pkg::*;
#(
   parameter int              ADDR_W = 16,
   parameter logic [ADDR_W-1:0] BASE = 16'h4000,
   parameter int              SLOTS  = WIN_SLOTS
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [SLOTS-1:0]  slot_o
);
   logic               in_win;
   logic [SLOT_W-1:0]  ofs;

   assign in_win = (addr_i[ADDR_W-1:SLOT_W] == BASE[ADDR_W-1:SLOT_W]);
   assign ofs    = addr_i[SLOT_W-1:0];

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      if (slot_unused(i)) begin : g_hole
         assign slot_o[i] = 1'b0;
      end else begin : g_used
         assign slot_o[i] = in_win && (ofs == SLOT_W'(i));
      end
   end
endmodule

// File: rtl/apu_fe_length.sv
module apu_fe_length
   import apu_fe_pkg::*;
#(
   parameter int SLOTS = WIN_SLOTS,
   parameter int NLEN  = TONE_CH,
   parameter int NCH   = ALL_CH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [SLOTS-1:0] slot_i,
   input  logic             en_wr_i,
   input  logic [NCH-1:0]   en_bits_i,
   input  logic [4:0]       idx_i,
   output logic [NCH-1:0]   ch_en_o,
   output logic [NLEN-1:0]  len_load_o,
   output logic [7:0]       len_value_o
);
   logic [NLEN-1:0] load_req;

   for (genvar c = 0; c < NLEN; c++) begin : g_ld
      assign load_req[c] = wr_i && slot_i[4*c+3] && ch_en_o[c];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_en_o     <= '0;
         len_load_o  <= '0;
         len_value_o <= '0;
      end else begin
         len_load_o <= load_req;
         if (|load_req) len_value_o <= len_lookup(idx_i);
         if (en_wr_i)   ch_en_o     <= en_bits_i;
      end
   end

   for (genvar c = 0; c < NLEN; c++) begin : g_chk
      AST_LOAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
         len_load_o[c] |-> $past(ch_en_o[c]) && $past(wr_i)); // R9
   end
   AST_EN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      !en_wr_i |=> $stable(ch_en_o)); // R7
endmodule

// File: rtl/apu_fe_irq.sv
module apu_fe_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_set_i,
   input  logic dmc_set_i,
   input  logic stat_rd_i,
   input  logic en_wr_i,
   input  logic frame_wr_i,
   input  logic inhibit_bit_i,
   output logic frame_flag_o,
   output logic dmc_flag_o
);
   logic inhibit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inhibit_q    <= 1'b0;
         frame_flag_o <= 1'b0;
         dmc_flag_o   <= 1'b0;
      end else begin
         if (frame_wr_i) inhibit_q <= inhibit_bit_i;
         if (frame_set_i && !inhibit_q)            frame_flag_o <= 1'b1;
         else if (frame_wr_i && inhibit_bit_i)     frame_flag_o <= 1'b0;
         else if (stat_rd_i)                       frame_flag_o <= 1'b0;
         if (dmc_set_i)    dmc_flag_o <= 1'b1;
         else if (en_wr_i) dmc_flag_o <= 1'b0;
      end
   end

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd_i && !frame_set_i |=> !frame_flag_o); // R5
   AST_READ_KEEPS_DMC: assert property (@(posedge clk) disable iff (!rst_n)
      stat_rd_i && dmc_flag_o && !en_wr_i |=> dmc_flag_o); // R5
   AST_FRAME_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_flag_o) |-> $past(frame_set_i) && !$past(inhibit_q)); // R6
   AST_ENWR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr_i && !dmc_set_i |=> !dmc_flag_o); // R7
endmodule

// File: rtl/apu_reg_front.sv
module apu_reg_front
   import apu_fe_pkg::*;
#(
   parameter int                ADDR_W = 16,
   parameter logic [ADDR_W-1:0] BASE   = 16'h4000,
   parameter int                SLOTS  = WIN_SLOTS,
   parameter int                NLEN   = TONE_CH,
   parameter int                NCH    = ALL_CH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [NLEN-1:0]   len_nz_i,
   input  logic              sample_busy_i,
   input  logic              frame_irq_set_i,
   input  logic              dmc_irq_set_i,
   output logic [SLOTS-1:0]  reg_we_o,
   output logic [7:0]        reg_wdata_o,
   output logic [NCH-1:0]    ch_en_o,
   output logic [NLEN-1:0]   len_load_o,
   output logic [7:0]        len_value_o,
   output logic [7:0]        rd_data_o,
   output logic              irq_o
);
   if (SLOTS != WIN_SLOTS) begin : g_bad_slots
      $error("SLOTS must equal the register window size");
   end
   if (NLEN + 1 != NCH || NCH > 8) begin : g_bad_ch
      $error("channel counts inconsistent with status layout");
   end

   logic [SLOTS-1:0] slot;
   logic             en_wr, frame_wr, stat_rd;
   logic             frame_flag, dmc_flag;

   apu_fe_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .SLOTS(SLOTS)) u_dec (
      .addr_i (bus_addr),
      .slot_o (slot)
   );

   assign en_wr    = bus_wr && slot[OFS_ENABLE];
   assign frame_wr = bus_wr && slot[OFS_FRAME];
   assign stat_rd  = bus_rd && slot[OFS_ENABLE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_we_o    <= '0;
         reg_wdata_o <= '0;
      end else begin
         reg_we_o <= bus_wr ? slot : '0;
         if (bus_wr) reg_wdata_o <= bus_wdata;
      end
   end

   apu_fe_length #(.SLOTS(SLOTS), .NLEN(NLEN), .NCH(NCH)) u_len (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_i        (bus_wr),
      .slot_i      (slot),
      .en_wr_i     (en_wr),
      .en_bits_i   (bus_wdata[NCH-1:0]),
      .idx_i       (bus_wdata[7:3]),
      .ch_en_o     (ch_en_o),
      .len_load_o  (len_load_o),
      .len_value_o (len_value_o)
   );

   apu_fe_irq u_irq (
      .clk           (clk),
      .rst_n         (rst_n),
      .frame_set_i   (frame_irq_set_i),
      .dmc_set_i     (dmc_irq_set_i),
      .stat_rd_i     (stat_rd),
      .en_wr_i       (en_wr),
      .frame_wr_i    (frame_wr),
      .inhibit_bit_i (bus_wdata[6]),
      .frame_flag_o  (frame_flag),
      .dmc_flag_o    (dmc_flag)
   );

   always_comb begin
      rd_data_o = '0;
      if (stat_rd) begin
         rd_data_o[NLEN-1:0] = len_nz_i;
         rd_data_o[NLEN]     = sample_busy_i;
         rd_data_o[6]        = frame_flag;
         rd_data_o[7]        = dmc_flag;
      end
   end

   assign irq_o = frame_flag | dmc_flag;

   AST_WE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_we_o)); // R1
   AST_WE_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (|reg_we_o) |-> $past(bus_wr)); // R1
   AST_HOLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && (bus_addr == BASE + ADDR_W'(20)) |=> (reg_we_o == '0) && (len_load_o == '0)); // R2
   AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(frame_irq_set_i || dmc_irq_set_i)); // R8
   AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (rd_data_o == '0)); // R4
endmodule

// File: tb/sim_apu_reg_front.sv
module sim_apu_reg_front;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [3:0]  len_nz = '0;
   logic        sbusy = 1'b0, fset = 1'b0, dset = 1'b0;
   logic [23:0] reg_we;
   logic [7:0]  reg_wdata, len_value, rd_data;
   logic [4:0]  ch_en;
   logic [3:0]  len_load;
   logic        irq;

   int checks = 0, fails = 0;
   logic [23:0] o_we;
   logic [7:0]  o_wd, o_lv, o_rd;
   logic [3:0]  o_ll;

   always #2.5 clk = ~clk;

   apu_reg_front u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .len_nz_i(len_nz), .sample_busy_i(sbusy),
      .frame_irq_set_i(fset), .dmc_irq_set_i(dset), .reg_we_o(reg_we),
      .reg_wdata_o(reg_wdata), .ch_en_o(ch_en), .len_load_o(len_load),
      .len_value_o(len_value), .rd_data_o(rd_data), .irq_o(irq)
   );

   typedef struct packed { logic [15:0] a; logic [7:0] d; logic [23:0] we; } vec_t;
   localparam vec_t VEC [0:14] = '{
      '{16'h4000, 8'h11, 24'h000001}, '{16'h4001, 8'h22, 24'h000002},
      '{16'h4002, 8'h33, 24'h000004}, '{16'h4005, 8'h44, 24'h000020},
      '{16'h4008, 8'h55, 24'h000100}, '{16'h4009, 8'h66, 24'h000000},
      '{16'h400A, 8'h77, 24'h000400}, '{16'h400D, 8'h88, 24'h000000},
      '{16'h4010, 8'h99, 24'h010000}, '{16'h4013, 8'hAA, 24'h080000},
      '{16'h4014, 8'hBB, 24'h000000}, '{16'h4016, 8'hCC, 24'h000000},
      '{16'h4018, 8'hDD, 24'h000000}, '{16'h3FF5, 8'hEE, 24'h000000},
      '{16'h5000, 8'h12, 24'h000000}};

   localparam logic [7:0] LTAB [0:31] = '{
      8'd10,8'd254,8'd20,8'd2,8'd40,8'd4,8'd80,8'd6,8'd160,8'd8,8'd60,8'd10,
      8'd14,8'd12,8'd26,8'd14,8'd12,8'd16,8'd24,8'd18,8'd48,8'd20,8'd96,8'd22,
      8'd192,8'd24,8'd72,8'd26,8'd16,8'd28,8'd32,8'd30};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      o_we = reg_we; o_wd = reg_wdata; o_ll = len_load; o_lv = len_value;
   endtask

   task automatic rd(input logic [15:0] a);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 o_rd = rd_data;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic pulse(input bit frame);
      @(negedge clk);
      if (frame) fset = 1'b1; else dset = 1'b1;
      @(negedge clk);
      fset = 1'b0; dset = 1'b0;
   endtask

   initial begin
      #750000;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 ch_en", 32'(ch_en), 0);
      check("R11 we", 32'(reg_we), 0);
      check("R11 irq", 32'(irq), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 len_load", 32'(len_load), 0);

      // R1 / R2 decode table (all channels disabled, so no loads)
      for (int i = 0; i < 15; i++) begin
         wr(VEC[i].a, VEC[i].d);
         check(VEC[i].we == 0 ? "R2 no strobe" : "R1 strobe", 32'(o_we), 32'(VEC[i].we));
         if (VEC[i].we != 0) check("R1 data", 32'(o_wd), 32'(VEC[i].d));
         check("R2 no load", 32'(o_ll), 0);
         @(negedge clk);
         check("R1 one cycle", 32'(reg_we), 0);
      end

      // R9 disabled channel gives no load
      wr(16'h4003, 8'h08);
      check("R9 gated off", 32'(o_ll), 0);
      check("R1 len slot strobe", 32'(o_we), 32'h8);

      // R7 enable write
      wr(16'h4015, 8'h1F);
      check("R7 ch_en", 32'(ch_en), 32'h1F);

      // R10 full table through channel 0
      for (int k = 0; k < 32; k++) begin
         wr(16'h4003, 8'(k << 3) | 8'h5);
         check("R9 load ch0", 32'(o_ll), 32'h1);
         check("R10 value", 32'(o_lv), 32'(LTAB[k]));
      end
      wr(16'h400F, 8'hF8);
      check("R9 load ch3", 32'(o_ll), 32'h8);
      check("R10 value idx31", 32'(o_lv), 32'd30);
      wr(16'h400B, 8'h10);
      check("R9 load ch2", 32'(o_ll), 32'h4);
      check("R10 value idx2", 32'(o_lv), 32'd20);

      // R7 disable channel 1, R9 its load is gated
      wr(16'h4015, 8'h1D);
      check("R7 ch_en", 32'(ch_en), 32'h1D);
      wr(16'h4007, 8'hF8);
      check("R9 disabled ch1", 32'(o_ll), 0);

      // R3/R4/R5/R8 frame flag
      len_nz = 4'b1010; sbusy = 1'b1;
      rd(16'h4015);
      check("R3 status idle", 32'(o_rd), 32'h1A);
      pulse(1);
      check("R8 irq frame", 32'(irq), 1);
      rd(16'h4014);
      check("R4 other read zero", 32'(o_rd), 0);
      check("R4 no clear", 32'(irq), 1);
      rd(16'h4015);
      check("R3 frame bit", 32'(o_rd), 32'h5A);
      check("R5 cleared", 32'(irq), 0);
      rd(16'h4015);
      check("R5 status after", 32'(o_rd), 32'h1A);

      // R5 read does not clear sample flag; R7 enable write does
      pulse(0);
      check("R8 irq dmc", 32'(irq), 1);
      rd(16'h4015);
      check("R3 dmc bit", 32'(o_rd), 32'h9A);
      rd(16'h4015);
      check("R5 dmc kept", 32'(o_rd), 32'h9A);
      pulse(1);
      wr(16'h4015, 8'h1F);
      rd(16'h4015);
      check("R7 dmc cleared frame kept", 32'(o_rd), 32'h5A);
      check("R8 irq none", 32'(irq), 0);

      // R6 inhibit
      pulse(1);
      wr(16'h4017, 8'h40);
      check("R6 inhibit clears", 32'(irq), 0);
      pulse(1);
      check("R6 inhibited set", 32'(irq), 0);
      wr(16'h4017, 8'h00);
      pulse(1);
      check("R6 set after uninhibit", 32'(irq), 1);
      // R6 set wins over status read clear
      @(negedge clk);
      fset = 1'b1; bus_addr = 16'h4015; bus_rd = 1'b1;
      @(negedge clk);
      fset = 1'b0; bus_rd = 1'b0;
      check("R6 set wins", 32'(irq), 1);
      // R7 set wins over enable-write clear
      rd(16'h4015);
      @(negedge clk);
      dset = 1'b1; bus_addr = 16'h4015; bus_wdata = 8'h1F; bus_wr = 1'b1;
      @(negedge clk);
      dset = 1'b0; bus_wr = 1'b0;
      check("R7 dmc set wins", 32'(irq), 1);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule